// File: doc/BRIEF.md
# Audio Packet Stream Gating Controller

This block sits in the audio path of a digital video transmitter. It chooses the audio packet type for each packet opportunity on the link. The choices are a real sample packet, a zero-filled silent sample packet, a null packet, or no audio packet. It also drives the enable for clock-regeneration (N/CTS) packet generation and reports whether audio is currently flowing.

Start and stop follow the video timing. After software raises the enable, the block waits for the next start of vertical blanking before it sends samples. After software drops the enable during active video, samples continue until that active region ends. When the sample buffer runs dry, silent-stream mode keeps the sink locked with flagged zero samples. Otherwise the block falls back to null packets. Fetching samples, serializing packets and the N/CTS arithmetic are handled elsewhere.

Top module: `apkt_gate_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, `pkt_type` is 2'b00 (none), and `cts_en` and `running` are 0.
- R2: After `aud_en` rises, `running` stays 0, and every slot gives `pkt_type` 2'b00, until a rising edge of `vblank` is seen with `aud_en` still high.
- R3: In the armed condition (`cts_en`=1, `running`=0), a cycle with `aud_en`=1 and a rising edge of `vblank` makes `running` 1 in the next cycle.
- R4: If `aud_en` falls while `running` is 1 and `active_video` is 1, `running` stays 1 and slots keep being served until `active_video` falls. `running` becomes 0 in the cycle after that falling edge is sampled.
- R5: If `aud_en` is 0 and `active_video` is 0 while `running` is 1, `running` is 0 in the next cycle.
- R6: If `aud_en` is cleared while armed, the block goes back to idle (`cts_en`=0) in the next cycle and emits no packet.
- R7: If `aud_en` is set again while draining, the block returns to running and does not wait for a vertical blank. It keeps running past the end of active video.
- R8: A `slot_req` while running with `buf_avail`=1 gives `pkt_type` 2'b01 (sample) in the next cycle. `buf_avail` is checked on every slot, so a buffer that arrives mid-frame gets samples at the next slot.
- R9: A `slot_req` while running with `buf_avail`=0 and `silent_en`=1 gives `pkt_type` 2'b10 (silent, flat zero samples) in the next cycle.
- R10: A `slot_req` while running with `buf_avail`=0 and `silent_en`=0 gives `pkt_type` 2'b11 (null) in the next cycle.
- R11: `cts_en` is 1 whenever the block is armed, running or draining, including during a silent stream. It is 0 only in idle.
- R12: In the cycle after a cycle without `slot_req`, `pkt_type` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aud_en | input | 1 | Audio enable control |
| silent_en | input | 1 | Send silent samples on underrun instead of null packets |
| buf_avail | input | 1 | A sample buffer is ready |
| vblank | input | 1 | Vertical blanking level |
| active_video | input | 1 | Active video level |
| slot_req | input | 1 | Packet opportunity in this cycle |
| pkt_type | output | 2 | 00 none, 01 sample, 10 silent, 11 null; one cycle after the slot |
| cts_en | output | 1 | Clock-regeneration packet enable |
| running | output | 1 | Audio samples are being served |

## Verification
A wrong controller state shows up on `running` and `cts_en` in the very next cycle. It also shows on the type reported one cycle after the next slot. A missed edge leaves `running` wrong for a whole video frame, and a bad underrun decision shows in the first slot after the buffer empties. The bench runs a reference model that tracks the state every clock. It steps through enable at mid-frame, cancel while armed, drain during active video, stop during blanking, re-enable while draining, and the three buffer and silent-mode combinations.

// File: rtl/apkt_pkg.sv
// Package: shared types for the audio packet gating controller.
// Assumes: packet type code values are decoded by the packet builder downstream.
package apkt_pkg;

    localparam int PKT_W       = 2;
    localparam int NUM_STROBES = 2;
    localparam int STB_VBLANK  = 0;
    localparam int STB_ACTIVE  = 1;

    typedef enum logic [PKT_W-1:0] {
        PKT_NONE   = 2'b00,
        PKT_SAMPLE = 2'b01,
        PKT_SILENT = 2'b10,
        PKT_NULL   = 2'b11
    } pkt_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_RUN   = 2'b10,
        ST_DRAIN = 2'b11
    } gate_state_t;

endpackage

// File: rtl/apkt_edge_det.sv
// Module: per-bit rising and falling edge detector for timing strobes.
// Assumes: inputs are synchronous to clk. The history is cleared in reset, so a
// level that is high when reset ends counts as a rising edge.
module apkt_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] hist_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Remember last cycle's level of this strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[b] <= 1'b0;
            else        hist_q[b] <= sig[b];
        end

        // Compare the current level with the remembered one.
        always_comb begin
            rise[b] = sig[b] & ~hist_q[b];
            fall[b] = ~sig[b] & hist_q[b];
        end
    end

endmodule

// File: rtl/apkt_state_ctl.sv
// Module: start/stop sequencer. It aligns enable to the next vertical blank
// and aligns disable to the end of active video.
// Assumes: the edge strobes come from apkt_edge_det in the same cycle as the level.
module apkt_state_ctl
    import apkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        aud_en,
    input  logic        active_video,
    input  logic        vblank_start,
    input  logic        active_end,
    output gate_state_t state
);

    gate_state_t nxt;

    // Next-state decision for the start/stop sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (aud_en) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!aud_en)           nxt = ST_IDLE;
                else if (vblank_start) nxt = ST_RUN;
            end
            ST_RUN:   if (!aud_en) nxt = active_video ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: begin
                if (aud_en)          nxt = ST_RUN;
                else if (active_end) nxt = ST_IDLE;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/apkt_slot_pick.sv
// Module: chooses the packet type for each slot request. The result is
// registered and valid in the cycle after the request.
// Assumes: buf_avail and silent_en are sampled only in a slot cycle.
module apkt_slot_pick
    import apkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  gate_state_t state,
    input  logic        slot_req,
    input  logic        buf_avail,
    input  logic        silent_en,
    output pkt_kind_t   pkt_type
);

    pkt_kind_t pick;
    logic      serving;

    // Work out what this slot would carry.
    always_comb begin
        serving = (state == ST_RUN) || (state == ST_DRAIN);
        if (!slot_req || !serving) pick = PKT_NONE;
        else if (buf_avail)        pick = PKT_SAMPLE;
        else if (silent_en)        pick = PKT_SILENT;
        else                       pick = PKT_NULL;
    end

    // Register the choice for the packet builder.
    always_ff @(posedge clk) begin
        if (!rst_n) pkt_type <= PKT_NONE;
        else        pkt_type <= pick;
    end

endmodule

// File: rtl/apkt_gate_ctrl.sv
// Module: top of the audio packet gating controller.
// Assumes: all inputs are synchronous to clk. Reset is synchronous, active low.
module apkt_gate_ctrl
    import apkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aud_en,
    input  logic             silent_en,
    input  logic             buf_avail,
    input  logic             vblank,
    input  logic             active_video,
    input  logic             slot_req,
    output logic [PKT_W-1:0] pkt_type,
    output logic             cts_en,
    output logic             running
);

    logic [NUM_STROBES-1:0] stb, stb_rise, stb_fall;
    gate_state_t            state;
    pkt_kind_t              kind;

    // Gather the timing strobes into one vector.
    always_comb begin
        stb             = '0;
        stb[STB_VBLANK] = vblank;
        stb[STB_ACTIVE] = active_video;
    end

    apkt_edge_det #(.W(NUM_STROBES)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (stb),
        .rise (stb_rise),
        .fall (stb_fall)
    );

    apkt_state_ctl i_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .aud_en      (aud_en),
        .active_video(active_video),
        .vblank_start(stb_rise[STB_VBLANK]),
        .active_end  (stb_fall[STB_ACTIVE]),
        .state       (state)
    );

    apkt_slot_pick i_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .slot_req (slot_req),
        .buf_avail(buf_avail),
        .silent_en(silent_en),
        .pkt_type (kind)
    );

    // Drive the outputs from the state and the selected packet type.
    always_comb begin
        pkt_type = kind;
        running  = (state == ST_RUN) || (state == ST_DRAIN);
        cts_en   = (state != ST_IDLE);
    end

endmodule

// File: rtl/apkt_gate_chk.sv
// Module: property checker for apkt_gate_ctrl, attached with bind.
// Assumes: it sees only the top-level ports.
module apkt_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       aud_en,
    input logic       silent_en,
    input logic       buf_avail,
    input logic       vblank,
    input logic       active_video,
    input logic       slot_req,
    input logic [1:0] pkt_type,
    input logic       cts_en,
    input logic       running
);

    assert_idle_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_req |=> pkt_type == 2'b00);

    assert_not_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !running) |=> pkt_type == 2'b00);

    assert_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && running && buf_avail) |=> pkt_type == 2'b01);

    assert_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && running && !buf_avail && silent_en) |=> pkt_type == 2'b10);

    assert_null_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && running && !buf_avail && !silent_en) |=> pkt_type == 2'b11);

    assert_cts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cts_en);

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en && !running && aud_en && $rose(vblank)) |=> running);

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !aud_en && !active_video) |=> !running);

endmodule

bind apkt_gate_ctrl apkt_gate_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .aud_en      (aud_en),
    .silent_en   (silent_en),
    .buf_avail   (buf_avail),
    .vblank      (vblank),
    .active_video(active_video),
    .slot_req    (slot_req),
    .pkt_type    (pkt_type),
    .cts_en      (cts_en),
    .running     (running)
);

// File: tb/test_apkt_gate_ctrl.sv
module test_apkt_gate_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aud_en = 1'b0, silent_en = 1'b0, buf_avail = 1'b0;
    logic       vblank = 1'b0, active_video = 1'b0, slot_req = 1'b0;
    logic [1:0] pkt_type;
    logic       cts_en, running;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // reference model state: 0 idle, 1 armed, 2 running, 3 draining
    int m_st = 0;
    bit m_vb = 0, m_av = 0;
    int m_pkt = 0;

    always #10 clk = ~clk;

    apkt_gate_ctrl i_apkt_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .aud_en(aud_en), .silent_en(silent_en),
        .buf_avail(buf_avail), .vblank(vblank), .active_video(active_video),
        .slot_req(slot_req), .pkt_type(pkt_type), .cts_en(cts_en), .running(running)
    );

    // behavioural reference
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_vb = 0; m_av = 0; m_pkt = 0;
        end else begin
            bit vb_start, av_end;
            vb_start = vblank && !m_vb;
            av_end   = !active_video && m_av;
            if (slot_req && (m_st == 2 || m_st == 3))
                m_pkt = buf_avail ? 1 : (silent_en ? 2 : 3);
            else
                m_pkt = 0;
            case (m_st)
                0: if (aud_en) m_st = 1;
                1: if (!aud_en) m_st = 0; else if (vb_start) m_st = 2;
                2: if (!aud_en) m_st = active_video ? 3 : 0;
                3: if (aud_en) m_st = 2; else if (av_end) m_st = 0;
                default: m_st = 0;
            endcase
            m_vb = vblank;
            m_av = active_video;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            check(cur_req, "pkt_type", int'(pkt_type), m_pkt);
            check(cur_req, "running", int'(running), (m_st == 2 || m_st == 3) ? 1 : 0);
            check(cur_req, "cts_en", int'(cts_en), (m_st != 0) ? 1 : 0);
        end
    end

    // video timing generator: frame of 30 cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            vblank       = (cnt < 6);
            active_video = (cnt >= 8 && cnt < 28);
            slot_req     = (cnt % 3 == 1);
            cnt          = (cnt + 1) % 30;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_run(bit lvl);
        while (running !== lvl && cycles < 20000) @(negedge clk);
    endtask

    // watchdog
    initial begin
        while (!done && cycles < 20000) @(negedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        wait_cyc(3);
        check("R1", "reset pkt_type", int'(pkt_type), 0);
        check("R1", "reset running", int'(running), 0);
        check("R1", "reset cts_en", int'(cts_en), 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1", "post-reset cts_en", int'(cts_en), 0);

        // mid-frame enable then cancel while armed
        wait_cyc(12);
        cur_req = "R2"; aud_en = 1'b1;
        wait_cyc(6);
        check("R2", "armed not running", int'(running), 0);
        cur_req = "R6"; aud_en = 1'b0;
        wait_cyc(2);
        check("R6", "cancel cts_en", int'(cts_en), 0);
        wait_cyc(30);

        // enable and start at vblank
        cur_req = "R3/R11"; aud_en = 1'b1; buf_avail = 1'b1;
        wait_run(1'b1);
        check("R11", "cts while running", int'(cts_en), 1);
        cur_req = "R8/R12"; wait_cyc(40);
        cur_req = "R9"; buf_avail = 1'b0; silent_en = 1'b1; wait_cyc(40);
        check("R11", "cts during silence", int'(cts_en), 1);
        cur_req = "R10"; silent_en = 1'b0; wait_cyc(40);
        cur_req = "R8"; buf_avail = 1'b1; wait_cyc(7);
        buf_avail = 1'b0; wait_cyc(5); buf_avail = 1'b1; wait_cyc(10);

        // disable inside active video: drain
        while (!active_video) @(negedge clk);
        wait_cyc(2);
        cur_req = "R4"; aud_en = 1'b0;
        wait_cyc(3);
        check("R4", "still running while draining", int'(running), 1);
        wait_cyc(40);

        // disable during blanking: immediate stop
        aud_en = 1'b1; cur_req = "R3";
        wait_run(1'b1);
        while (active_video || !vblank) @(negedge clk);
        cur_req = "R5"; aud_en = 1'b0;
        wait_cyc(2);
        check("R5", "stopped in blanking", int'(running), 0);
        wait_cyc(10);

        // re-enable while draining
        aud_en = 1'b1; cur_req = "R3";
        wait_run(1'b1);
        while (!active_video) @(negedge clk);
        cur_req = "R7"; aud_en = 1'b0;
        wait_cyc(3);
        aud_en = 1'b1;
        wait_cyc(30);
        check("R7", "running after re-enable", int'(running), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule